// File: doc/BRIEF.md
# UART Receive Queue with Per-Character Error Tags

This block is the receive-side holding queue of a 16550-class serial port. The deframer hands over each received character together with the error flags detected for it. The queue keeps the character and its flags side by side in one 16-bit slot. The host drains the slots in arrival order through its data-register read strobe. The queue runs either as a 16-slot ring or as a single holding slot, chosen by a FIFO-enable control bit.

Error flags are not posted to line status when a character arrives. A slot's flags are folded into the accumulated line-status byte only once that slot sits at the read end of the queue, and the flags in the slot are wiped at that moment. Software therefore sees each character's errors exactly when that character is next to be read, and a status clear is not undone by the same flags being applied again.

The block also keeps a data-ready flag and a sticky overrun indication. It has a character-timeout counter that advances on character-time ticks while data is waiting. A receive-reset control empties the queue.

Top module: `uart_rx_tagq`

## Requirements
- R1: The queue holds at most 16 slots while `fifo_en_i` is 1 and at most 1 slot while it is 0. Any change of `fifo_en_i` empties the queue and clears data-ready, like a receive reset. Out of reset the depth is 1.
- R2: Characters leave in arrival order. `head_char_o` shows the oldest stored character, or 0 when the queue is empty. A `pop_i` on a non-empty queue removes the oldest slot, and a `pop_i` on an empty queue has no effect.
- R3: A `push_i` that finds the queue full, with no accepted pop in the same cycle, discards the character. It sets line-status bit 1 (overrun, also on `overrun_o`) and bit 7 (receive error).
- R4: Every push, kept or discarded, sets data-ready (`data_ready_o`, also line-status bit 0) and zeroes the timeout counter. Data-ready clears when a pop leaves the queue empty with no push in that cycle.
- R5: A stored character keeps only its low 5 + `wlen_i` bits; its higher bits read as zero.
- R6: Of `push_stat_i`, only bit 2 (parity), bit 3 (frame), bit 4 (break) and bit 7 (receive error) are kept in the slot. One cycle after a slot becomes the oldest, its kept bits are ORed into line status and wiped from the slot, so they are applied only once.
- R7: `rx_reset_i` empties the queue, clears data-ready and zeroes the timeout counter. It wins over a push or pop in the same cycle.
- R8: The timeout counter rises by one on each `tick_i` cycle while data-ready is set, and it saturates at its maximum.
- R9: `lsr_clr_i` clears line-status bits 7..1. An error bit raised in the same cycle, by a merge or an overrun, survives the clear.
- R10: A push and a pop in the same cycle on a full queue are both accepted, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fifo_en_i | input | 1 | 1 selects the 16-slot ring, 0 the single slot |
| rx_reset_i | input | 1 | Empties the queue |
| wlen_i | input | 2 | Word length code; data width is 5 + code |
| push_i | input | 1 | A received character is offered |
| push_char_i | input | 8 | Received character |
| push_stat_i | input | 8 | Error flags captured with the character |
| pop_i | input | 1 | Host data-register read |
| tick_i | input | 1 | One character-time has elapsed |
| lsr_clr_i | input | 1 | Host line-status read clear |
| head_char_o | output | 8 | Oldest stored character |
| data_ready_o | output | 1 | Data-ready flag |
| overrun_o | output | 1 | Sticky overrun flag |
| timeout_o | output | TMO_W | Character-timeout counter |
| line_stat_o | output | 8 | Accumulated line status, bit 0 is data-ready |

## Verification
The queue is driven with long random streams of pushes, pops, ticks and status clears. These streams run in both depth modes and at all word lengths, and they tell ordering and wrap faults apart from faults in the count. Directed patterns then cover the edges the random mix seldom reaches: overfilling each depth by one, a push and a pop together on a full queue, and a flagged character that must raise its error bits one cycle after it becomes the oldest and never again after a clear. Resets and mode changes made in the middle of traffic separate the emptying rules from normal draining.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LS_DR  = 0;
  localparam int LS_OVR = 1;
  localparam int LS_ERR = 7;
  // flags kept per slot: parity(2) frame(3) break(4) receive error(7)
  localparam logic [7:0] TAG_KEEP = 8'h9C;
  localparam logic [7:0] OVR_BITS = 8'h82;

  function automatic logic [7:0] char_keep(input logic [1:0] wlen);
    return 8'((9'd1 << (5 + int'(wlen))) - 9'd1);
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int SLOTS = 16,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [15:0]   wr_data,
  input  logic          wipe_en,
  input  logic [AW-1:0] rd_idx,
  output logic [15:0]   rd_data
);
  logic [15:0] slot_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [15:0] slot_d;
    logic        wr_hit, wipe_hit;
    assign wr_hit   = wr_en   && (wr_idx == AW'(i));
    assign wipe_hit = wipe_en && (rd_idx == AW'(i));
    always_comb begin
      slot_d = slot_q[i];
      if (wipe_hit) slot_d[15:8] = 8'h00;
      if (wr_hit)   slot_d = wr_data;   // a new slot wins over the wipe
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  slot_q[i] <= '0;
      else if (wr_hit || wipe_hit) slot_q[i] <= slot_d;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int SLOTS = 16,
  parameter int AW    = $clog2(SLOTS),
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en_i,
  input  logic          rx_reset_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          flush,
  output logic          accept,
  output logic          pop_ok,
  output logic          overflow,
  output logic          has_entry,
  output logic          empty_next,
  output logic [AW-1:0] head_ptr,
  output logic [AW-1:0] tail_ptr
);
  logic          big_q, big_d;
  logic [AW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d, depth;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic big);
    if (!big || p == AW'(SLOTS - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign depth     = big_q ? CW'(SLOTS) : CW'(1);
  assign flush     = rx_reset_i || (fifo_en_i != big_q);
  assign has_entry = (cnt_q != '0);
  assign pop_ok    = pop_i && has_entry && !flush;
  assign accept    = push_i && !flush && ((cnt_q < depth) || pop_ok);
  assign overflow  = push_i && !flush && !accept;

  always_comb begin
    big_d  = big_q;
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      big_d  = fifo_en_i;
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (accept) head_d = step_ptr(head_q, big_q);
      if (pop_ok) tail_d = step_ptr(tail_q, big_q);
      cnt_d = cnt_q + CW'(accept) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big_q  <= 1'b0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      big_q  <= big_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign empty_next = (cnt_d == '0);
  assign head_ptr   = head_q;
  assign tail_ptr   = tail_q;

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= depth);
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !flush && cnt_q == depth && !pop_i) |=> $stable(cnt_q));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && head_q == '0 && tail_q == '0));
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_i,
  input  logic             pop_ok,
  input  logic             overflow,
  input  logic             empty_next,
  input  logic             has_entry,
  input  logic [7:0]       head_tag,
  input  logic             lsr_clr_i,
  input  logic             tick_i,
  output logic             ready_o,
  output logic [7:0]       lsr_o,
  output logic [TMO_W-1:0] tmo_o
);
  logic [7:0]       lsr_q, lsr_d;
  logic             dr_q, dr_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;

  always_comb begin
    lsr_d = lsr_clr_i ? 8'h00 : lsr_q;
    if (has_entry) lsr_d = lsr_d | head_tag;
    if (overflow)  lsr_d = lsr_d | OVR_BITS;
    lsr_d[LS_DR] = 1'b0;

    dr_d = dr_q;
    if (flush)                     dr_d = 1'b0;
    else if (push_i)               dr_d = 1'b1;
    else if (pop_ok && empty_next) dr_d = 1'b0;

    tmo_d = tmo_q;
    if (flush || push_i)                      tmo_d = '0;
    else if (tick_i && dr_q && tmo_q != '1)   tmo_d = tmo_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsr_q <= '0;
      dr_q  <= 1'b0;
      tmo_q <= '0;
    end else begin
      lsr_q <= lsr_d;
      dr_q  <= dr_d;
      tmo_q <= tmo_d;
    end
  end

  assign ready_o = dr_q;
  assign lsr_o   = {lsr_q[7:1], dr_q};
  assign tmo_o   = tmo_q;

  a_r3_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (lsr_q[LS_OVR] && lsr_q[LS_ERR]));
  a_r4_push_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !flush) |=> (dr_q && tmo_q == '0));
  a_r8_tmo_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && dr_q && !push_i && !flush && tmo_q != '1) |=> (tmo_q == $past(tmo_q) + 1'b1));
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_q[LS_OVR] && !lsr_clr_i) |=> lsr_q[LS_OVR]);
endmodule

// File: rtl/uart_rx_tagq.sv
module uart_rx_tagq
  import rxq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en_i,
  input  logic             rx_reset_i,
  input  logic [1:0]       wlen_i,
  input  logic             push_i,
  input  logic [7:0]       push_char_i,
  input  logic [7:0]       push_stat_i,
  input  logic             pop_i,
  input  logic             tick_i,
  input  logic             lsr_clr_i,
  output logic [7:0]       head_char_o,
  output logic             data_ready_o,
  output logic             overrun_o,
  output logic [TMO_W-1:0] timeout_o,
  output logic [7:0]       line_stat_o
);
  localparam int AW = $clog2(SLOTS);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          flush, accept, pop_ok, overflow, has_entry, empty_next;
  logic [AW-1:0] head_ptr, tail_ptr;
  logic [15:0]   wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_data = {push_stat_i & TAG_KEEP, push_char_i & char_keep(wlen_i)};

  rxq_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .fifo_en_i(fifo_en_i), .rx_reset_i(rx_reset_i),
    .push_i(push_i), .pop_i(pop_i), .flush(flush), .accept(accept), .pop_ok(pop_ok),
    .overflow(overflow), .has_entry(has_entry), .empty_next(empty_next),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr)
  );

  rxq_store #(.SLOTS(SLOTS)) u_store (
    .clk(clk), .rst_n(rst_int_n), .wr_en(accept), .wr_idx(head_ptr), .wr_data(wr_data),
    .wipe_en(has_entry), .rd_idx(tail_ptr), .rd_data(rd_data)
  );

  rxq_status #(.TMO_W(TMO_W)) u_status (
    .clk(clk), .rst_n(rst_int_n), .flush(flush), .push_i(push_i), .pop_ok(pop_ok),
    .overflow(overflow), .empty_next(empty_next), .has_entry(has_entry),
    .head_tag(rd_data[15:8]), .lsr_clr_i(lsr_clr_i), .tick_i(tick_i),
    .ready_o(data_ready_o), .lsr_o(line_stat_o), .tmo_o(timeout_o)
  );

  assign head_char_o = has_entry ? rd_data[7:0] : 8'h00;
  assign overrun_o   = line_stat_o[LS_OVR];

  a_r6_tag_once: assert property (@(posedge clk) disable iff (!rst_int_n)
    (has_entry && !accept) |=> (rd_data[15:8] == 8'h00 || !$stable(tail_ptr)));
  a_r2_empty_head_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !has_entry |-> head_char_o == 8'h00);
endmodule

// File: tb/uart_rx_tagq_bench.sv
module uart_rx_tagq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fe = 1'b0, rr = 1'b0, ps = 1'b0, po = 1'b0, tk = 1'b0, cl = 1'b0;
  logic [1:0] wl = 2'd3;
  logic [7:0] pc = 8'h00, pst = 8'h00;
  logic [7:0] head_char, line_stat, tmo;
  logic dready, ovr;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  byte unsigned mq_c[$];
  byte unsigned mq_t[$];
  bit m_big = 0, m_dr = 0;
  byte unsigned m_lsr = 0, m_tmo = 0;

  always #2 clk = ~clk;

  uart_rx_tagq u_uart_rx_tagq (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fe), .rx_reset_i(rr), .wlen_i(wl),
    .push_i(ps), .push_char_i(pc), .push_stat_i(pst), .pop_i(po), .tick_i(tk),
    .lsr_clr_i(cl), .head_char_o(head_char), .data_ready_o(dready),
    .overrun_o(ovr), .timeout_o(tmo), .line_stat_o(line_stat)
  );

  function automatic byte unsigned keep_mask(input logic [1:0] w);
    return byte'((9'd1 << (5 + int'(w))) - 1);
  endfunction

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit flush, popok, acc;
    int depth;
    byte unsigned lsr_n;
    lsr_n = cl ? 8'h00 : m_lsr;
    if (mq_c.size() > 0) begin lsr_n |= mq_t[0]; mq_t[0] = 0; end
    flush = rr || (fe != m_big);
    depth = m_big ? 16 : 1;
    if (flush) begin
      mq_c.delete(); mq_t.delete(); m_dr = 0; m_tmo = 0; m_big = fe;
    end else begin
      popok = po && mq_c.size() > 0;
      acc = ps && (mq_c.size() < depth || popok);
      if (popok) begin void'(mq_c.pop_front()); void'(mq_t.pop_front()); end
      if (acc) begin mq_c.push_back(pc & keep_mask(wl)); mq_t.push_back(pst & 8'h9C); end
      if (ps && !acc) lsr_n |= 8'h82;
      if (ps) m_tmo = 0;
      else if (tk && m_dr && m_tmo != 8'hFF) m_tmo++;
      if (ps) m_dr = 1;
      else if (popok && mq_c.size() == 0) m_dr = 0;
    end
    m_lsr = lsr_n & 8'hFE;
  endtask

  task automatic step(input bit p, input byte unsigned c, input byte unsigned s,
                      input bit pp, input bit r, input bit k, input bit t);
    ps = p; pc = c; pst = s; po = pp; rr = r; cl = k; tk = t;
    @(posedge clk);
    #1;
    model_step();
    expect_eq("R2 head", head_char, mq_c.size() > 0 ? mq_c[0] : 0);
    expect_eq("R4 ready", dready, m_dr);
    expect_eq("R6 line status", line_stat, m_lsr | m_dr);
    expect_eq("R3 overrun out", ovr, m_lsr[1]);
    expect_eq("R8 timeout", tmo, m_tmo);
    ps = 0; po = 0; rr = 0; cl = 0; tk = 0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // reset state
    expect_eq("R4 reset ready", dready, 0);
    expect_eq("R6 reset status", line_stat, 0);
    expect_eq("R8 reset timeout", tmo, 0);

    // R1 depth 1, R3 overrun on second push
    wl = 2'd3;
    step(1, 8'hA1, 0, 0, 0, 0, 0);
    step(1, 8'hB2, 0, 0, 0, 0, 0);
    expect_eq("R1 single slot keeps first", head_char, 8'hA1);
    expect_eq("R3 overrun+error bits", line_stat & 8'h82, 8'h82);
    // R10 push and pop together on a full single slot
    step(1, 8'hC3, 0, 1, 0, 1, 0);
    expect_eq("R10 new head", head_char, 8'hC3);
    expect_eq("R10 no overrun", line_stat & 8'h82, 8'h00);
    expect_eq("R9 cleared", line_stat, 8'h01);
    // R8 ticks while ready
    repeat (3) step(0, 0, 0, 0, 0, 0, 1);
    expect_eq("R8 three ticks", tmo, 3);
    // R7 receive reset
    step(0, 0, 0, 0, 1, 0, 0);
    expect_eq("R7 empty head", head_char, 0);
    expect_eq("R7 ready clear", dready, 0);

    // R1 switch to 16 slots and overfill by one
    fe = 1'b1;
    idle();
    for (int i = 0; i < 17; i++) step(1, byte'(8'h10 + i), 0, 0, 0, 0, 0);
    expect_eq("R3 seventeenth dropped", ovr, 1);
    expect_eq("R2 oldest first", head_char, 8'h10);
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0, 0, 0);
    expect_eq("R1 sixteenth still held", head_char, 8'h1F);
    step(0, 0, 0, 1, 0, 0, 0);
    expect_eq("R1 drained after sixteen", dready, 0);
    step(0, 0, 0, 1, 0, 1, 0);
    expect_eq("R2 pop on empty", head_char, 0);

    // R5 word length masking
    wl = 2'd0;
    step(1, 8'hFF, 0, 0, 0, 0, 0);
    expect_eq("R5 five bit char", head_char, 8'h1F);
    step(0, 0, 0, 1, 0, 0, 0);

    // R6 tag merges one cycle after reaching the read end, once only
    wl = 2'd3;
    step(1, 8'h55, 8'hFF, 0, 0, 0, 0);
    expect_eq("R6 not yet merged", line_stat, 8'h01);
    idle();
    expect_eq("R6 merged", line_stat, 8'h9D);
    step(0, 0, 0, 0, 0, 1, 0);
    expect_eq("R6 cleared not reapplied", line_stat, 8'h01);
    idle();
    expect_eq("R6 still clear", line_stat, 8'h01);
    // R1 mode change empties
    fe = 1'b0;
    idle();
    expect_eq("R1 mode change empties", dready, 0);

    // random traffic
    for (int ph = 0; ph < 8; ph++) begin
      fe = ph[0];
      for (int i = 0; i < 400; i++) begin
        wl = 2'($urandom_range(0, 3));
        step($urandom_range(0, 99) < 45, 8'($urandom), 8'($urandom_range(0, 9) == 0 ? $urandom : 0),
             $urandom_range(0, 99) < 40, $urandom_range(0, 199) == 0,
             $urandom_range(0, 19) == 0, $urandom_range(0, 3) == 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule